// File: doc/BRIEF.md
# Static LCD Segment Drive Generator

This block drives a non-multiplexed seven-segment liquid crystal panel showing three and a half digits plus a minus sign. A free-running counter on the oscillator clock produces a square-wave backplane with a 50% duty cycle. Every segment line is a copy of that backplane: a dark segment moves in phase with it, and a lit segment is inverted. Each segment therefore sees either no voltage or a full alternating swing, and never a net DC level.

The reading is given as three binary-coded-decimal digits (units, tens, hundreds), a leading half-digit bit and a negative flag. These inputs are sampled only on a one-cycle latch strobe, so the panel holds steady while the converter works on the next result. With the default half period of 400 oscillator cycles, the backplane period is 800 oscillator cycles. That is twenty backplane periods per 16000-cycle conversion.

Top module: `lcd_static_drive`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `backplane` = 0 and every segment output = 0, and the stored display content is cleared to all segments dark.
- R2: After reset, `backplane` holds each level for exactly HALF_PERIOD clock cycles and then toggles, starting low for the first HALF_PERIOD cycles.
- R3: A dark segment output is equal to `backplane` in every cycle.
- R4: A lit segment output is equal to the inverse of `backplane` in every cycle.
- R5: Digit k (k=0 units, 1 tens, 2 hundreds) takes its BCD code from `bcd_digits[4k+3:4k]` and drives `seg_digits[7k+6:7k]`, with bit 0 = a up to bit 6 = g. Lit patterns as hex a..g masks: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F.
- R6: BCD codes 10 to 15 leave all seven segments of that digit dark.
- R7: New display content is taken only on a clock edge where `latch` is 1 and shows from the next cycle. Input changes without `latch` have no effect on any output.
- R8: `seg_half` is lit when `half_digit` was 1 at the last latch, and dark otherwise.
- R9: `seg_minus` is lit when `negative` was 1 at the last latch, and dark otherwise.
- R10: With fixed content, every segment output is high for exactly HALF_PERIOD cycles of each 2*HALF_PERIOD-cycle backplane period, so it has no DC bias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| latch | input | 1 | One-cycle strobe that captures the display inputs |
| bcd_digits | input | 12 | Units, tens and hundreds BCD codes, units in the low nibble |
| half_digit | input | 1 | Leading half digit shows "1" when set |
| negative | input | 1 | Minus sign shows when set |
| backplane | output | 1 | Square-wave common electrode drive |
| seg_digits | output | 21 | Segment lines a..g for units, tens and hundreds |
| seg_half | output | 1 | Segment line for the leading "1" |
| seg_minus | output | 1 | Minus-sign segment line |

## Verification
Every BCD code from 0 to 15 is latched into each digit position in turn, with other codes in the neighbouring digits. This separates a wrong glyph from a swapped digit position and shows that codes 10 to 15 are blanked. The sign and half-digit bits are toggled on their own, so that a wrong phase on one extra line cannot hide behind the digits. Inputs are also changed while the strobe stays low, which shows that the display holds its content. Duty counts over a full backplane period, taken on one lit and one dark line, show whether a segment carries DC bias.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

    localparam int NUM_DIGITS = 3;
    localparam int SEG_W      = 7;
    localparam int BCD_W      = 4;

    typedef logic [SEG_W-1:0] seg_t;

    typedef struct packed {
        logic                  minus;
        logic                  half;
        seg_t [NUM_DIGITS-1:0] dig;
    } lit_t;

    // bit 0 = a ... bit 6 = g; out-of-range codes blank
    function automatic seg_t bcd_to_seg(input logic [BCD_W-1:0] code);
        seg_t s;
        case (code)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lcd_bp_gen.sv
module lcd_bp_gen #(
    parameter int HALF_PERIOD = 400
) (
    input  logic clk,
    input  logic rst,
    output logic bp
);
    localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            bp  <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            bp  <= ~bp;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lcd_seg_latch.sv
module lcd_seg_latch
    import lcd_drv_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          latch,
    input  logic [NUM_DIGITS*BCD_W-1:0]   bcd_digits,
    input  logic                          half_digit,
    input  logic                          negative,
    output lit_t                          lit
);
    lit_t next_lit;

    generate
        for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dec
            assign next_lit.dig[k] = bcd_to_seg(bcd_digits[k*BCD_W +: BCD_W]);
        end
    endgenerate
    assign next_lit.half  = half_digit;
    assign next_lit.minus = negative;

    always_ff @(posedge clk) begin
        if (rst)        lit <= '0;
        else if (latch) lit <= next_lit;
    end
endmodule

// File: rtl/lcd_seg_xor.sv
module lcd_seg_xor
    import lcd_drv_pkg::*;
(
    input  logic                        bp,
    input  lit_t                        lit,
    output logic [NUM_DIGITS*SEG_W-1:0] seg_digits,
    output logic                        seg_half,
    output logic                        seg_minus
);
    generate
        for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_drv
            assign seg_digits[k*SEG_W +: SEG_W] = lit.dig[k] ^ {SEG_W{bp}};
        end
    endgenerate
    assign seg_half  = lit.half  ^ bp;
    assign seg_minus = lit.minus ^ bp;
endmodule

// File: rtl/lcd_static_drive.sv
module lcd_static_drive
    import lcd_drv_pkg::*;
#(
    parameter int HALF_PERIOD = 400
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        latch,
    input  logic [NUM_DIGITS*BCD_W-1:0] bcd_digits,
    input  logic                        half_digit,
    input  logic                        negative,
    output logic                        backplane,
    output logic [NUM_DIGITS*SEG_W-1:0] seg_digits,
    output logic                        seg_half,
    output logic                        seg_minus
);
    lit_t lit;

    lcd_bp_gen #(.HALF_PERIOD(HALF_PERIOD)) u_bp (
        .clk (clk),
        .rst (rst),
        .bp  (backplane)
    );

    lcd_seg_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .latch      (latch),
        .bcd_digits (bcd_digits),
        .half_digit (half_digit),
        .negative   (negative),
        .lit        (lit)
    );

    lcd_seg_xor u_xor (
        .bp         (backplane),
        .lit        (lit),
        .seg_digits (seg_digits),
        .seg_half   (seg_half),
        .seg_minus  (seg_minus)
    );
endmodule

// File: rtl/lcd_static_drive_chk.sv
module lcd_static_drive_chk
    import lcd_drv_pkg::*;
#(
    parameter int HALF_PERIOD = 400
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        latch,
    input logic                        half_digit,
    input logic                        negative,
    input logic                        backplane,
    input logic [NUM_DIGITS*SEG_W-1:0] seg_digits,
    input logic                        seg_half,
    input logic                        seg_minus
);
    localparam int RW   = $clog2(HALF_PERIOD + 1) + 1;
    localparam int ALLW = NUM_DIGITS*SEG_W + 2;

    logic [ALLW-1:0] all_seg;
    assign all_seg = {seg_minus, seg_half, seg_digits};

    logic          prev_bp;
    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_bp <= 1'b0;
            run     <= '0;
        end else begin
            prev_bp <= backplane;
            run     <= (backplane != prev_bp) ? RW'(1) : run + 1'b1;
        end
    end

    // R1
    p_reset_dark_r1: assert property (@(posedge clk)
        rst |=> (!backplane && all_seg == '0));

    // R2: a level is left only after exactly HALF_PERIOD cycles
    p_bp_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        (backplane != prev_bp) |-> (run == RW'(HALF_PERIOD)));

    p_bp_max_r2: assert property (@(posedge clk) disable iff (rst)
        (run <= RW'(HALF_PERIOD)));

    // R3/R4: without new content every line flips with the backplane
    p_seg_follow_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(latch) && !$stable(backplane))
            |-> (all_seg == ~$past(all_seg)));

    // R7: no strobe, no backplane edge -> nothing moves
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(latch) && $stable(backplane))
            |-> $stable(all_seg));

    // R9
    p_minus_r9: assert property (@(posedge clk) disable iff (rst)
        (latch && negative) |=> (seg_minus != backplane));

    // R8
    p_half_r8: assert property (@(posedge clk) disable iff (rst)
        (latch && !half_digit) |=> (seg_half == backplane));

endmodule

bind lcd_static_drive lcd_static_drive_chk #(.HALF_PERIOD(HALF_PERIOD)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .latch      (latch),
    .half_digit (half_digit),
    .negative   (negative),
    .backplane  (backplane),
    .seg_digits (seg_digits),
    .seg_half   (seg_half),
    .seg_minus  (seg_minus)
);

// File: tb/lcd_static_drive_tb.sv
module lcd_static_drive_tb;
    localparam int HALF = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        latch = 1'b0;
    logic [11:0] bcd_digits = '0;
    logic        half_digit = 1'b0;
    logic        negative = 1'b0;
    logic        backplane;
    logic [20:0] seg_digits;
    logic        seg_half;
    logic        seg_minus;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lcd_static_drive #(.HALF_PERIOD(HALF)) u_dut (
        .clk(clk), .rst(rst), .latch(latch), .bcd_digits(bcd_digits),
        .half_digit(half_digit), .negative(negative), .backplane(backplane),
        .seg_digits(seg_digits), .seg_half(seg_half), .seg_minus(seg_minus)
    );

    // glyph table from R5 (bit0=a .. bit6=g), codes 10..15 dark per R6
    function automatic logic [6:0] glyph(input int code);
        logic [6:0] g [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                               7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
        if (code < 10) return g[code];
        return 7'h00;
    endfunction

    // behavioural reference model
    int          m_cnt = 0;
    logic        m_bp = 1'b0;
    logic [20:0] m_lit = '0;
    logic        m_half = 1'b0;
    logic        m_neg = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_bp = 1'b0; m_lit = '0; m_half = 1'b0; m_neg = 1'b0;
        end else begin
            m_cnt = m_cnt + 1;
            if (m_cnt == HALF) begin
                m_cnt = 0;
                m_bp = ~m_bp;
            end
            if (latch) begin
                for (int k = 0; k < 3; k++)
                    m_lit[7*k +: 7] = glyph(int'(bcd_digits[4*k +: 4]));
                m_half = half_digit;
                m_neg  = negative;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check("R2 backplane", 32'(backplane), 32'(m_bp));
            for (int i = 0; i < 21; i++) begin
                if (seg_digits[i] !== (m_lit[i] ^ m_bp)) begin
                    if (m_lit[i]) check("R4 lit digit segment",  32'(seg_digits[i]), 32'(!m_bp));
                    else          check("R3 dark digit segment", 32'(seg_digits[i]), 32'(m_bp));
                end
            end
            check("R8 half line",  32'(seg_half),  32'(m_half ^ m_bp));
            check("R9 minus line", 32'(seg_minus), 32'(m_neg ^ m_bp));
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [11:0] d, input logic h, input logic n);
        @(negedge clk); #1;
        bcd_digits = d; half_digit = h; negative = n; latch = 1'b1;
        @(negedge clk); #1;
        latch = 1'b0;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        cycles(4);
        // R1: reset state
        check("R1 backplane in reset", 32'(backplane), 32'h0);
        check("R1 segments in reset", 32'({seg_minus, seg_half, seg_digits}), 32'h0);
        #1 rst = 1'b0;

        // R2: first toggle after exactly HALF cycles
        cycles(HALF - 1);
        check("R2 still low", 32'(backplane), 32'h0);
        cycles(1);
        check("R2 toggled high", 32'(backplane), 32'h1);

        // R5/R6: sweep every code through each digit position
        for (int pos = 0; pos < 3; pos++) begin
            for (int c = 0; c < 16; c++) begin
                logic [11:0] d;
                d = 12'h000;
                d[4*pos +: 4] = 4'(c);
                d[4*((pos+1)%3) +: 4] = 4'((c + 3) % 10);
                load(d, c[0], c[1]);
                cycles(3);
                check((c < 10) ? "R5 glyph" : "R6 blank",
                      32'(seg_digits[7*pos +: 7] ^ {7{backplane}}), 32'(glyph(c)));
            end
        end

        // R7: inputs move without the strobe
        load(12'h852, 1'b1, 1'b0);
        cycles(2);
        #1 bcd_digits = 12'h111; half_digit = 1'b0; negative = 1'b1;
        cycles(5);
        check("R7 held digits", 32'(seg_digits ^ {21{backplane}}),
              32'({glyph(8), glyph(5), glyph(2)}));
        check("R7 held minus", 32'(seg_minus ^ backplane), 32'h0);
        check("R8 half lit", 32'(seg_half ^ backplane), 32'h1);

        // R9 / R8 isolated
        load(12'hFFF, 1'b0, 1'b1);
        cycles(2);
        check("R9 minus lit", 32'(seg_minus ^ backplane), 32'h1);
        check("R8 half dark", 32'(seg_half ^ backplane), 32'h0);

        // R10: duty over a full period, lit minus and dark units a
        load(12'h001, 1'b0, 1'b1);
        begin
            int hi_minus = 0;
            int hi_a = 0;
            for (int t = 0; t < 2*HALF; t++) begin
                @(negedge clk);
                if (seg_minus)     hi_minus++;
                if (seg_digits[0]) hi_a++;
            end
            check("R10 lit duty",  32'(hi_minus), 32'(HALF));
            check("R10 dark duty", 32'(hi_a),     32'(HALF));
        end

        // R1: reset mid-run clears content
        #1 rst = 1'b1;
        cycles(2);
        #1 rst = 1'b0;
        check("R1 cleared after reset", 32'({seg_minus, seg_half, seg_digits, backplane}), 32'h0);
        cycles(HALF + 10);
        finish_run();
    end
endmodule